// File: doc/BRIEF.md
# USB Device Endpoint Control Unit

This unit keeps the register state of a single USB device endpoint and decides, one token at a time, how that endpoint answers the host. Software reaches it through a small word-addressed register port. The port exposes the endpoint configuration, the payload length, the packet-buffer segment and a control word that holds stall and cancel. The protocol engine presents each decoded token with its type and endpoint number. It later pulses a completion strobe that carries the received byte count. The unit replies with a registered response code. From its state it also drives the data PID to use, the start address of the endpoint's buffer and the transmit length.

Software arms the endpoint by writing the payload length. For an IN endpoint that value is the byte count to send. For an OUT endpoint it is the largest byte count that will be accepted. After a transfer completes, the same register reads back the bytes moved. The data toggle is seeded by software and flips by itself after every completed IN transfer. Stall is a software-held flag. It can also be lifted by a SETUP token when the configuration allows that.

Top module: `usb_ep_ctrl`

## Requirements
- R1: After reset every register reads 0, no response is issued, the endpoint is unarmed and buf_addr_o equals BUF_BASE.
- R2: The segment register (address 2) keeps its value in bits [8:3], and buf_addr_o = BUF_BASE + (segment << 3), so buffers are 8-byte aligned.
- R3: The configuration register is at address 0, with mode in [1:0] (0 off, 1 OUT, 2 IN, 3 invalid), isochronous in [2], toggle in [3], setup-unstall enable in [4] and endpoint number in [11:8]. A token (type 0 OUT, 1 IN, 2 SETUP, 3 none) gets no response when the mode is off or invalid, when the endpoint number differs, or when the direction does not fit. IN fits mode 2; OUT and SETUP fit mode 1.
- R4: A matching token on an unarmed, non-stalled, non-isochronous endpoint gets NAK (code 0) on the following cycle.
- R5: Bit 0 of the control register (address 3) is the stall flag. While it is set, a matching non-isochronous token gets STALL (code 1), and stall overrides both NAK and data.
- R6: With setup-unstall enabled, a matching SETUP token clears the stall flag and is answered as if no stall were set.
- R7: Writing the length register (address 1) arms the endpoint. A matching token on an armed endpoint gets DATA (code 2). The completion strobe then gives ACK (code 3) on the next cycle and disarms the endpoint.
- R8: An isochronous endpoint never issues NAK, STALL or ACK. When armed it gives DATA; when unarmed it gives nothing.
- R9: data_pid_o shows the toggle bit (0 = DATA0, 1 = DATA1). It inverts after each completed IN transfer, and a configuration write sets it.
- R10: The length register reads back the IN byte count unchanged. For OUT it reads back the received count, capped at the armed maximum. tx_len_o shows the register.
- R11: Writing 1 to control bit 1 disarms an idle endpoint, and the bit always reads 0. During a transfer in progress the write has no effect.
- R12: Tokens that arrive while a transfer is in progress get no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 12 | Register write data |
| reg_rdata_o | output | 12 | Register read data, combinational on reg_addr_i |
| tok_valid_i | input | 1 | Token event strobe |
| tok_type_i | input | 2 | Token type: 0 OUT, 1 IN, 2 SETUP |
| tok_ep_i | input | 4 | Token endpoint number |
| done_i | input | 1 | Transaction complete strobe |
| done_cnt_i | input | LEN_W+1 | Received byte count for OUT |
| resp_valid_o | output | 1 | Response present this cycle |
| resp_o | output | 2 | Response: 0 NAK, 1 STALL, 2 DATA, 3 ACK |
| data_pid_o | output | 1 | Data PID to use: 0 DATA0, 1 DATA1 |
| buf_addr_o | output | ADDR_W | Buffer start address |
| tx_len_o | output | LEN_W | Current length register |

## Verification
The embedded properties check four rules on every cycle. Every non-ACK response traces back to a token that matched the previous cycle, and every ACK traces back to a completion during a transfer. An isochronous endpoint never hands out a handshake. A transfer in progress always implies an armed endpoint. Toggle inversion, the cap on the OUT count and the immunity of a transfer in progress to cancel are also checked each time they occur. Only the bench scenarios can show the whole sequence. That includes which of NAK, STALL and DATA wins in each state, the exact register read-back values, the buffer address arithmetic, and the way stall is lifted through SETUP.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  localparam int EPN_W = 4;
  localparam int REG_W = 12;

  typedef enum logic [1:0] {TOK_OUT = 2'd0, TOK_IN = 2'd1, TOK_SETUP = 2'd2, TOK_NONE = 2'd3} tok_e;
  typedef enum logic [1:0] {EP_OFF = 2'd0, EP_OUT = 2'd1, EP_IN = 2'd2, EP_BAD = 2'd3} ep_mode_e;
  typedef enum logic [1:0] {RSP_NAK = 2'd0, RSP_STALL = 2'd1, RSP_DATA = 2'd2, RSP_ACK = 2'd3} rsp_e;

  localparam logic [1:0] A_CFG  = 2'd0;
  localparam logic [1:0] A_LEN  = 2'd1;
  localparam logic [1:0] A_SEG  = 2'd2;
  localparam logic [1:0] A_CTRL = 2'd3;

  localparam int CFG_ISO_BIT  = 2;
  localparam int CFG_DSQ_BIT  = 3;
  localparam int CFG_UNST_BIT = 4;
  localparam int CFG_EPN_LSB  = 8;
  localparam int SEG_LSB      = 3;
  localparam int CTRL_STALL   = 0;
  localparam int CTRL_CANCEL  = 1;
endpackage

// File: rtl/ep_reg_file.sv
module ep_reg_file import usb_ep_pkg::*; #(
  parameter int LEN_W = 9,
  parameter int SEG_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic [LEN_W-1:0] len_i,
  input  logic             dsq_i,
  input  logic             stall_i,
  output logic [1:0]       mode_o,
  output logic             iso_o,
  output logic             unst_o,
  output logic [EPN_W-1:0] epn_o,
  output logic [SEG_W-1:0] seg_o,
  output logic             cfg_we_o,
  output logic             len_we_o,
  output logic             ctrl_we_o,
  output logic [LEN_W-1:0] wr_len_o,
  output logic             wr_dsq_o,
  output logic             wr_stall_o,
  output logic             wr_cancel_o
);
  assign cfg_we_o    = we_i && (addr_i == A_CFG);
  assign len_we_o    = we_i && (addr_i == A_LEN);
  assign ctrl_we_o   = we_i && (addr_i == A_CTRL);
  assign wr_len_o    = wdata_i[LEN_W-1:0];
  assign wr_dsq_o    = wdata_i[CFG_DSQ_BIT];
  assign wr_stall_o  = wdata_i[CTRL_STALL];
  assign wr_cancel_o = wdata_i[CTRL_CANCEL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      iso_o  <= 1'b0;
      unst_o <= 1'b0;
      epn_o  <= '0;
      seg_o  <= '0;
    end else begin
      if (cfg_we_o) begin
        mode_o <= wdata_i[1:0];
        iso_o  <= wdata_i[CFG_ISO_BIT];
        unst_o <= wdata_i[CFG_UNST_BIT];
        epn_o  <= wdata_i[CFG_EPN_LSB +: EPN_W];
      end
      if (we_i && addr_i == A_SEG) seg_o <= wdata_i[SEG_LSB +: SEG_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CFG: begin
        rdata_o[1:0]                     = mode_o;
        rdata_o[CFG_ISO_BIT]             = iso_o;
        rdata_o[CFG_DSQ_BIT]             = dsq_i;
        rdata_o[CFG_UNST_BIT]            = unst_o;
        rdata_o[CFG_EPN_LSB +: EPN_W]    = epn_o;
      end
      A_LEN:  rdata_o[LEN_W-1:0]         = len_i;
      A_SEG:  rdata_o[SEG_LSB +: SEG_W]  = seg_o;
      default: rdata_o[CTRL_STALL]       = stall_i; // cancel bit reads 0
    endcase
  end
endmodule

// File: rtl/ep_tok_match.sv
module ep_tok_match import usb_ep_pkg::*; (
  input  logic             tok_valid_i,
  input  logic [1:0]       tok_type_i,
  input  logic [EPN_W-1:0] tok_ep_i,
  input  logic [EPN_W-1:0] epn_i,
  input  logic [1:0]       mode_i,
  input  logic             busy_i,
  output logic             hit_o,
  output logic             hit_in_o,
  output logic             hit_setup_o
);
  tok_e     ty;
  ep_mode_e md;
  logic     dir_ok;

  assign ty = tok_e'(tok_type_i);
  assign md = ep_mode_e'(mode_i);

  always_comb begin
    case (md)
      EP_OUT:  dir_ok = (ty == TOK_OUT) || (ty == TOK_SETUP);
      EP_IN:   dir_ok = (ty == TOK_IN);
      default: dir_ok = 1'b0;
    endcase
  end

  assign hit_o       = tok_valid_i && !busy_i && (tok_ep_i == epn_i) && dir_ok;
  assign hit_in_o    = hit_o && (ty == TOK_IN);
  assign hit_setup_o = hit_o && (ty == TOK_SETUP);
endmodule

// File: rtl/ep_xact_ctrl.sv
module ep_xact_ctrl import usb_ep_pkg::*; #(
  parameter int LEN_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             hit_in_i,
  input  logic             hit_setup_i,
  input  logic             iso_i,
  input  logic             unst_i,
  input  logic             done_i,
  input  logic [LEN_W:0]   done_cnt_i,
  input  logic             cfg_we_i,
  input  logic             len_we_i,
  input  logic             ctrl_we_i,
  input  logic [LEN_W-1:0] wr_len_i,
  input  logic             wr_dsq_i,
  input  logic             wr_stall_i,
  input  logic             wr_cancel_i,
  output logic             busy_o,
  output logic             dsq_o,
  output logic             stall_o,
  output logic [LEN_W-1:0] len_o,
  output logic             resp_valid_o,
  output logic [1:0]       resp_o
);
  logic             armed_q, busy_q, cur_in_q, dsq_q, stall_q, rv_q;
  logic [LEN_W-1:0] len_q, cap_len;
  rsp_e             rsp_q;
  logic             stall_eff, cancel_we;

  assign stall_eff = stall_q && !(hit_setup_i && unst_i);
  assign cancel_we = ctrl_we_i && wr_cancel_i;
  assign cap_len   = (done_cnt_i > {1'b0, len_q}) ? len_q : done_cnt_i[LEN_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      busy_q   <= 1'b0;
      cur_in_q <= 1'b0;
      dsq_q    <= 1'b0;
      stall_q  <= 1'b0;
      len_q    <= '0;
      rv_q     <= 1'b0;
      rsp_q    <= RSP_NAK;
    end else begin
      rv_q <= 1'b0;
      if (hit_i) begin
        if (hit_setup_i && unst_i) stall_q <= 1'b0;
        if (iso_i) begin
          if (armed_q) begin
            rv_q     <= 1'b1;
            rsp_q    <= RSP_DATA;
            busy_q   <= 1'b1;
            cur_in_q <= hit_in_i;
          end
        end else if (stall_eff) begin
          rv_q  <= 1'b1;
          rsp_q <= RSP_STALL;
        end else if (!armed_q) begin
          rv_q  <= 1'b1;
          rsp_q <= RSP_NAK;
        end else begin
          rv_q     <= 1'b1;
          rsp_q    <= RSP_DATA;
          busy_q   <= 1'b1;
          cur_in_q <= hit_in_i;
        end
      end
      if (done_i && busy_q) begin
        busy_q  <= 1'b0;
        armed_q <= 1'b0;
        if (!iso_i) begin
          rv_q  <= 1'b1;
          rsp_q <= RSP_ACK;
        end
        if (cur_in_q) dsq_q <= ~dsq_q;
        else          len_q <= cap_len;
      end
      // software writes take priority over hardware updates
      if (cfg_we_i) dsq_q <= wr_dsq_i;
      if (len_we_i) begin
        len_q   <= wr_len_i;
        armed_q <= 1'b1;
      end
      if (ctrl_we_i) begin
        stall_q <= wr_stall_i;
        if (wr_cancel_i && !busy_q) armed_q <= 1'b0;
      end
    end
  end

  assign busy_o       = busy_q;
  assign dsq_o        = dsq_q;
  assign stall_o      = stall_q;
  assign len_o        = len_q;
  assign resp_valid_o = rv_q;
  assign resp_o       = rsp_q;

  p_resp_from_token_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rv_q && rsp_q != RSP_ACK) |-> $past(hit_i));
  p_ack_from_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rv_q && rsp_q == RSP_ACK) |-> $past(done_i && busy_q));
  p_iso_silent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rv_q && rsp_q != RSP_DATA) |-> !$past(iso_i));
  p_dsq_flip_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && busy_q && cur_in_q && !cfg_we_i) |=> (dsq_q != $past(dsq_q)));
  p_len_capped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && busy_q && !cur_in_q && !len_we_i) |=> (len_q <= $past(len_q)));
  p_cancel_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cancel_we && busy_q && !done_i) |=> armed_q);
  p_busy_armed_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> armed_q);
endmodule

// File: rtl/usb_ep_ctrl.sv
module usb_ep_ctrl import usb_ep_pkg::*; #(
  parameter int              LEN_W    = 9,
  parameter int              SEG_W    = 6,
  parameter int              ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] BUF_BASE = 12'h100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              tok_valid_i,
  input  logic [1:0]        tok_type_i,
  input  logic [EPN_W-1:0]  tok_ep_i,
  input  logic              done_i,
  input  logic [LEN_W:0]    done_cnt_i,
  output logic              resp_valid_o,
  output logic [1:0]        resp_o,
  output logic              data_pid_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [LEN_W-1:0]  tx_len_o
);
  localparam int OFS_W = SEG_W + SEG_LSB;

  logic [1:0]       mode;
  logic             iso, unst, busy, dsq, stall;
  logic [EPN_W-1:0] epn;
  logic [SEG_W-1:0] seg;
  logic [LEN_W-1:0] len, wr_len;
  logic             cfg_we, len_we, ctrl_we, wr_dsq, wr_stall, wr_cancel;
  logic             hit, hit_in, hit_setup;

  ep_reg_file #(.LEN_W(LEN_W), .SEG_W(SEG_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .len_i(len), .dsq_i(dsq), .stall_i(stall),
    .mode_o(mode), .iso_o(iso), .unst_o(unst), .epn_o(epn), .seg_o(seg),
    .cfg_we_o(cfg_we), .len_we_o(len_we), .ctrl_we_o(ctrl_we),
    .wr_len_o(wr_len), .wr_dsq_o(wr_dsq), .wr_stall_o(wr_stall), .wr_cancel_o(wr_cancel)
  );

  ep_tok_match u_match (
    .tok_valid_i, .tok_type_i, .tok_ep_i,
    .epn_i(epn), .mode_i(mode), .busy_i(busy),
    .hit_o(hit), .hit_in_o(hit_in), .hit_setup_o(hit_setup)
  );

  ep_xact_ctrl #(.LEN_W(LEN_W)) u_xact (
    .clk_i, .rst_ni,
    .hit_i(hit), .hit_in_i(hit_in), .hit_setup_i(hit_setup),
    .iso_i(iso), .unst_i(unst),
    .done_i, .done_cnt_i,
    .cfg_we_i(cfg_we), .len_we_i(len_we), .ctrl_we_i(ctrl_we),
    .wr_len_i(wr_len), .wr_dsq_i(wr_dsq), .wr_stall_i(wr_stall), .wr_cancel_i(wr_cancel),
    .busy_o(busy), .dsq_o(dsq), .stall_o(stall), .len_o(len),
    .resp_valid_o, .resp_o
  );

  assign buf_addr_o = BUF_BASE + ADDR_W'({seg, {SEG_LSB{1'b0}}});
  assign data_pid_o = dsq;
  assign tx_len_o   = len;

  initial begin
    if (ADDR_W < OFS_W) $error("ADDR_W too small for segment offset");
  end
endmodule

// File: tb/usb_ep_ctrl_tb_top.sv
module usb_ep_ctrl_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [1:0]  reg_addr = 0;
  logic [11:0] reg_wdata = 0, reg_rdata;
  logic        tok_valid = 0;
  logic [1:0]  tok_type = 0;
  logic [3:0]  tok_ep = 0;
  logic        done = 0;
  logic [9:0]  done_cnt = 0;
  logic        resp_valid, data_pid;
  logic [1:0]  resp;
  logic [11:0] buf_addr;
  logic [8:0]  tx_len;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  usb_ep_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tok_valid_i(tok_valid), .tok_type_i(tok_type), .tok_ep_i(tok_ep),
    .done_i(done), .done_cnt_i(done_cnt),
    .resp_valid_o(resp_valid), .resp_o(resp), .data_pid_o(data_pid),
    .buf_addr_o(buf_addr), .tx_len_o(tx_len)
  );

  // behavioural reference model
  int m_mode, m_ep, m_seg, m_len, m_rc;
  bit m_iso, m_unst, m_dsq, m_stall, m_armed, m_busy, m_in, m_rv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_ep = 0; m_seg = 0; m_len = 0; m_rc = 0;
      m_iso = 0; m_unst = 0; m_dsq = 0; m_stall = 0;
      m_armed = 0; m_busy = 0; m_in = 0; m_rv = 0;
    end else begin
      bit was_busy, match;
      int ty;
      ty = tok_type;
      was_busy = m_busy;
      m_rv = 0;
      match = tok_valid && !was_busy && (tok_ep == m_ep) &&
              ((m_mode == 1 && (ty == 0 || ty == 2)) || (m_mode == 2 && ty == 1));
      if (match) begin
        if (ty == 2 && m_unst) m_stall = 0;
        if (m_iso) begin
          if (m_armed) begin m_rv = 1; m_rc = 2; m_busy = 1; m_in = (ty == 1); end
        end else if (m_stall) begin m_rv = 1; m_rc = 1; end
        else if (!m_armed) begin m_rv = 1; m_rc = 0; end
        else begin m_rv = 1; m_rc = 2; m_busy = 1; m_in = (ty == 1); end
      end
      if (done && was_busy) begin
        m_busy = 0; m_armed = 0;
        if (!m_iso) begin m_rv = 1; m_rc = 3; end
        if (m_in) m_dsq = !m_dsq;
        else if (done_cnt < m_len) m_len = done_cnt;
      end
      if (reg_we) begin
        case (reg_addr)
          0: begin
            m_mode = reg_wdata[1:0]; m_iso = reg_wdata[2]; m_dsq = reg_wdata[3];
            m_unst = reg_wdata[4]; m_ep = reg_wdata[11:8];
          end
          1: begin m_len = reg_wdata[8:0]; m_armed = 1; end
          2: m_seg = reg_wdata[8:3];
          default: begin
            m_stall = reg_wdata[0];
            if (reg_wdata[1] && !was_busy) m_armed = 0;
          end
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      chk("R3 R4 R5 R7 R8 model resp_valid", 32'(resp_valid), 32'(m_rv));
      if (m_rv) chk("R4 R5 R7 R8 model resp code", 32'(resp), 32'(m_rc));
      chk("R9 model data_pid", 32'(data_pid), 32'(m_dsq));
      chk("R2 model buf_addr", 32'(buf_addr), 32'(256 + m_seg * 8));
      chk("R10 model tx_len", 32'(tx_len), 32'(m_len));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [11:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [11:0] exp, input string tag);
    @(negedge clk); reg_addr = a; #1;
    chk(tag, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic tok(input logic [1:0] ty, input logic [3:0] ep,
                     input bit ev, input logic [1:0] ec, input string tag);
    @(negedge clk); tok_valid = 1; tok_type = ty; tok_ep = ep;
    @(posedge clk); #1;
    chk(tag, 32'(resp_valid), 32'(ev));
    if (ev) chk(tag, 32'(resp), 32'(ec));
    @(negedge clk); tok_valid = 0;
  endtask

  task automatic dn(input logic [9:0] cnt, input bit ev, input string tag);
    @(negedge clk); done = 1; done_cnt = cnt;
    @(posedge clk); #1;
    chk(tag, 32'(resp_valid), 32'(ev));
    if (ev) chk(tag, 32'(resp), 32'(3));
    @(negedge clk); done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, 0, "R1 cfg"); rd(1, 0, "R1 len"); rd(2, 0, "R1 seg"); rd(3, 0, "R1 ctrl");
    chk("R1 resp_valid", 32'(resp_valid), 0);
    chk("R1 buf_addr", 32'(buf_addr), 32'h100);
    // R2 segment
    wr(2, 12'h150);
    rd(2, 12'h150, "R2 seg readback");
    chk("R2 buf_addr", 32'(buf_addr), 32'h250);
    // R3 matching, R4 NAK
    wr(0, 12'h501);
    tok(0, 3, 0, 0, "R3 other ep");
    tok(1, 5, 0, 0, "R3 wrong dir");
    tok(3, 5, 0, 0, "R3 no token type");
    tok(0, 5, 1, 0, "R4 unarmed NAK");
    // R7 arm and complete, R12 busy
    wr(1, 16);
    tok(0, 5, 1, 2, "R7 DATA");
    tok(0, 5, 0, 0, "R12 busy ignored");
    dn(10, 1, "R7 ACK");
    rd(1, 10, "R10 OUT count");
    tok(0, 5, 1, 0, "R7 disarmed NAK");
    // R10 truncation
    wr(1, 8);
    tok(0, 5, 1, 2, "R10 DATA");
    dn(20, 1, "R10 ACK");
    rd(1, 8, "R10 capped");
    chk("R10 tx_len", 32'(tx_len), 8);
    // R5 stall, R6 setup unstall
    wr(3, 1);
    rd(3, 1, "R5 stall readback");
    tok(0, 5, 1, 1, "R5 STALL unarmed");
    wr(1, 4);
    tok(0, 5, 1, 1, "R5 STALL armed");
    tok(2, 5, 1, 1, "R6 SETUP unstall off");
    wr(0, 12'h511);
    tok(2, 5, 1, 2, "R6 SETUP clears stall");
    rd(3, 0, "R6 stall cleared");
    dn(3, 1, "R6 ACK");
    // R11 cancel
    wr(1, 6);
    wr(3, 2);
    rd(3, 0, "R11 cancel reads 0");
    tok(0, 5, 1, 0, "R11 cancelled NAK");
    wr(1, 6);
    tok(0, 5, 1, 2, "R11 DATA");
    wr(3, 2);
    dn(6, 1, "R11 cancel ignored in transfer");
    rd(1, 6, "R11 len");
    // R9 toggle on IN
    wr(0, 12'h502);
    chk("R9 pid seed 0", 32'(data_pid), 0);
    wr(1, 12);
    tok(1, 5, 1, 2, "R9 IN DATA");
    dn(0, 1, "R9 IN ACK");
    chk("R9 pid toggled", 32'(data_pid), 1);
    rd(1, 12, "R10 IN len kept");
    wr(1, 5);
    tok(1, 5, 1, 2, "R9 IN DATA 2");
    dn(0, 1, "R9 IN ACK 2");
    chk("R9 pid toggled back", 32'(data_pid), 0);
    wr(0, 12'h50A);
    chk("R9 pid written", 32'(data_pid), 1);
    rd(0, 12'h50A, "R3 cfg readback");
    // R8 isochronous
    wr(0, 12'h506);
    tok(1, 5, 0, 0, "R8 iso unarmed silent");
    wr(3, 1);
    tok(1, 5, 0, 0, "R8 iso ignores stall");
    wr(1, 7);
    tok(1, 5, 1, 2, "R8 iso DATA");
    dn(0, 0, "R8 iso no ACK");
    chk("R8 iso toggle", 32'(data_pid), 1);
    wr(3, 0);
    // R3 disabled / invalid modes
    wr(0, 12'h500);
    tok(0, 5, 0, 0, "R3 disabled");
    wr(0, 12'h503);
    tok(0, 5, 0, 0, "R3 invalid OUT");
    tok(1, 5, 0, 0, "R3 invalid IN");
    repeat (2) @(negedge clk);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule